// File: doc/BRIEF.md
# Serial Converter Command Receiver

This block is the serial front end of an eight-channel, 12-bit converter control path. A host drives an active-low select, a serial clock and a data line. While select is low the block takes one data bit on every falling edge of the serial clock and builds a 16-bit command, most significant bit first. The upper four bits of a command choose what to do, and the lower twelve bits are the value.

A command takes effect only when select goes high after exactly sixteen captured bits. In that case the block decodes the control field and issues a single-cycle strobe to the register bank that sits next to it. The strobe is either a load of one channel's input register or a request to move every input register to its output register. A separate data output carries the bit that falls out of the far end of the 16-bit shift register, so several receivers can be chained on one bus.

All three serial pins are treated as asynchronous. Each passes through a two-stage synchronizer into the system clock before any edge is detected. The system clock must run at least four times faster than the serial clock.

Top module: `dac_cmd_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_stb_o`, `xfer_all_o` and `sdo_o` are 0. After reset the shift register is all zeros and select is taken as high.
- R2: Data is captured on each falling serial clock edge while select is low, and the first bit lands in the most significant position. When select rises after 16 bits with control field 0..7 (bits 15:12), `wr_stb_o` pulses for one cycle. During that pulse `wr_chan_o` equals control bits 14:12 and `wr_data_o` equals bits 11:0.
- R3: If select rises after any bit count other than 16 (for example 15 or 17), no strobe of either kind is issued.
- R4: Control field 4'b1000 pulses `xfer_all_o` for one cycle and does not pulse `wr_stb_o`.
- R5: Control field 4'b1111 (no-operation) and codes 4'b1001 to 4'b1110 produce no strobe at all.
- R6: Each captured bit moves `sdo_o` to the bit captured sixteen captures earlier, or to 0 if fewer than sixteen earlier captures exist since reset. The shift register is never cleared between commands.
- R7: A pin change reaches the outputs three system clocks later: two synchronizer stages plus one register.
- R8: Serial clock edges while select is high are ignored: they capture nothing and leave `sdo_o` unchanged.
- R9: Select may be high for a single system clock between commands. The first bit of the next command may fall together with select going low. The committed command stays intact and that bit is counted as bit one of the new command.
- R10: `wr_stb_o` and `xfer_all_o` are never high together, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Active-low select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Chain output, the bit shifted out of the 16-bit register |
| wr_stb_o | output | 1 | One-cycle channel load strobe |
| wr_chan_o | output | 3 | Channel index for the load |
| wr_data_o | output | 12 | Value for the load |
| xfer_all_o | output | 1 | One-cycle request to move all input registers to outputs |

## Verification
Two things can land in the same system cycle: the commit of one command and the capture of the first bit of the next. This happens when select is high for just one system clock and the next falling serial clock arrives together with select going low. The bench provokes this directly. It then compares the committed channel and value against the earlier command, and the chain output against the bit history, both cycle by cycle. Frames of 15 and 17 bits, and serial clock activity with select high, check that a miscount or a stray edge cannot produce a strobe or move the chain output.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
    localparam int WORD_W  = 16;
    localparam int CTRL_W  = 4;
    localparam int DATA_W  = WORD_W - CTRL_W;
    localparam int N_CHAN  = 8;
    localparam int CHAN_W  = $clog2(N_CHAN);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int SYNC_W  = 3;

    localparam logic [CTRL_W-1:0] CODE_XFER = 4'b1000;
    localparam logic [CTRL_W-1:0] CODE_NOP  = 4'b1111;

    typedef enum logic [1:0] {OP_IGNORE, OP_LOAD, OP_XFER_ALL, OP_NOP} op_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic csn;
        logic sclk;
        logic sdi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{csn: 1'b1, sclk: 1'b1, sdi: 1'b0};

    function automatic op_e decode_op(input logic [CTRL_W-1:0] c);
        if (c < CTRL_W'(N_CHAN)) return OP_LOAD;
        if (c == CODE_XFER)      return OP_XFER_ALL;
        if (c == CODE_NOP)       return OP_NOP;
        return OP_IGNORE;
    endfunction
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta, stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= RST_VAL[i];
                stable <= RST_VAL[i];
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/dac_rx_shift.sv
module dac_rx_shift
    import dac_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pins_t            pin_s,
    output logic             sdo,
    output logic             frame_ok,
    output word_t            word,
    output logic [CNT_W-1:0] bit_cnt
);
    logic              csn_d, sclk_d;
    logic [WORD_W-1:0] shreg;
    logic              cs_fall, cs_rise, sclk_fall;

    assign cs_fall   = csn_d & ~pin_s.csn;
    assign cs_rise   = ~csn_d & pin_s.csn;
    assign sclk_fall = sclk_d & ~pin_s.sclk & ~pin_s.csn;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d   <= 1'b1;
            sclk_d  <= 1'b1;
            shreg   <= '0;
            bit_cnt <= '0;
            sdo     <= 1'b0;
        end else begin
            csn_d  <= pin_s.csn;
            sclk_d <= pin_s.sclk;
            if (cs_fall)
                bit_cnt <= sclk_fall ? CNT_W'(1) : '0;
            else if (sclk_fall && bit_cnt != CNT_W'(CNT_MAX))
                bit_cnt <= bit_cnt + CNT_W'(1);
            if (sclk_fall) begin
                shreg <= {shreg[WORD_W-2:0], pin_s.sdi};
                sdo   <= shreg[WORD_W-1];
            end
        end
    end

    assign frame_ok = cs_rise && (bit_cnt == CNT_W'(WORD_W));
    assign word     = word_t'(shreg);
endmodule

// File: rtl/dac_rx_decode.sv
module dac_rx_decode
    import dac_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_ok,
    input  word_t             word,
    output logic              wr_stb,
    output logic [CHAN_W-1:0] wr_chan,
    output logic [DATA_W-1:0] wr_data,
    output logic              xfer_all
);
    op_e op;
    assign op = decode_op(word.ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb   <= 1'b0;
            xfer_all <= 1'b0;
            wr_chan  <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb   <= frame_ok && (op == OP_LOAD);
            xfer_all <= frame_ok && (op == OP_XFER_ALL);
            if (frame_ok && op == OP_LOAD) begin
                wr_chan <= word.ctrl[CHAN_W-1:0];
                wr_data <= word.data;
            end
        end
    end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
    import dac_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              wr_stb_o,
    output logic [CHAN_W-1:0] wr_chan_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              xfer_all_o
);
    pins_t            pin_raw, pin_s;
    logic             frame_ok;
    word_t            word;
    logic [CNT_W-1:0] bit_cnt;
    logic             csn_s;

    assign pin_raw = '{csn: csn_i, sclk: sclk_i, sdi: sdi_i};

    dac_rx_sync #(.W(SYNC_W), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
    );

    assign csn_s = pin_s.csn;

    dac_rx_shift u_shift (
        .clk(clk), .rst(rst), .pin_s(pin_s), .sdo(sdo_o),
        .frame_ok(frame_ok), .word(word), .bit_cnt(bit_cnt)
    );

    dac_rx_decode u_dec (
        .clk(clk), .rst(rst), .frame_ok(frame_ok), .word(word),
        .wr_stb(wr_stb_o), .wr_chan(wr_chan_o), .wr_data(wr_data_o),
        .xfer_all(xfer_all_o)
    );
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk
    import dac_rx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             csn_s,
    input logic             sdo_o,
    input logic             wr_stb_o,
    input logic             xfer_all_o,
    input logic [CNT_W-1:0] bit_cnt
);
    // R1: outputs quiet after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!wr_stb_o && !xfer_all_o && !sdo_o));

    // R3: a strobe follows only a cycle where exactly 16 bits were counted
    a_r3_exact_count: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o || xfer_all_o) |-> ($past(bit_cnt) == CNT_W'(WORD_W)));

    // R8: chain output holds while select is high
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> $stable(sdo_o));

    // R10: strobes are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb_o && xfer_all_o));

    // R10: load strobe lasts one cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    // R10: transfer strobe lasts one cycle
    a_r10_xfer_one_cycle: assert property (@(posedge clk) disable iff (rst)
        xfer_all_o |=> !xfer_all_o);
endmodule

bind dac_cmd_rx dac_cmd_rx_chk u_chk (
    .clk(clk), .rst(rst), .csn_s(csn_s), .sdo_o(sdo_o),
    .wr_stb_o(wr_stb_o), .xfer_all_o(xfer_all_o), .bit_cnt(bit_cnt)
);

// File: tb/tb_dac_cmd_rx.sv
module tb_dac_cmd_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csn_i = 1'b1, sclk_i = 1'b1, sdi_i = 1'b0;
    logic        sdo_o, wr_stb_o, xfer_all_o;
    logic [2:0]  wr_chan_o;
    logic [11:0] wr_data_o;

    always #10 clk = ~clk;

    dac_cmd_rx dut (
        .clk(clk), .rst(rst), .csn_i(csn_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .sdo_o(sdo_o), .wr_stb_o(wr_stb_o), .wr_chan_o(wr_chan_o),
        .wr_data_o(wr_data_o), .xfer_all_o(xfer_all_o)
    );

    typedef struct { int c; logic v; } sev_t;
    typedef struct { int c; int kind; logic [2:0] ch; logic [11:0] d; } cev_t;

    int     vectors = 0, fails = 0, cyc = 0;
    bit     done = 0;
    string  cur_req = "R2";
    logic   hist[$];
    sev_t   sdo_q[$];
    cev_t   cmt_q[$];
    logic   exp_sdo = 1'b0;
    logic   pc = 1'b1, ps = 1'b1;
    int     bcnt = 0;
    logic [15:0] mword = '0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cyc %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Model: outputs follow pin changes three system clocks later (R7)
    task automatic apply(logic c, logic s, logic d);
        bit cfall, crise, sfall;
        logic [3:0] ctrl;
        cfall = pc && !c;
        crise = !pc && c;
        sfall = ps && !s && !c;
        if (cfall) bcnt = 0;
        if (sfall) begin
            hist.push_back(d);
            mword = {mword[14:0], d};
            if (bcnt < 17) bcnt++;
            sdo_q.push_back('{c: cyc + 3,
                v: (hist.size() > 16) ? hist[hist.size() - 17] : 1'b0});
        end
        if (crise && bcnt == 16) begin
            ctrl = mword[15:12];
            if (ctrl < 4'd8)
                cmt_q.push_back('{c: cyc + 3, kind: 1, ch: ctrl[2:0], d: mword[11:0]});
            else if (ctrl == 4'b1000)
                cmt_q.push_back('{c: cyc + 3, kind: 2, ch: 3'd0, d: 12'd0});
        end
        pc = c; ps = s;
        csn_i = c; sclk_i = s; sdi_i = d;
    endtask

    task automatic tk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(logic b);
        apply(1'b0, 1'b1, b); tk(2);
        apply(1'b0, 1'b0, b); tk(4);
        apply(1'b0, 1'b1, b); tk(2);
    endtask

    task automatic frame(logic [16:0] w, int n);
        apply(1'b0, 1'b1, 1'b0); tk(4);
        for (int i = 0; i < n; i++) bit_cycle(w[n-1-i]);
        apply(1'b1, 1'b1, 1'b0); tk(10);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!done && cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    always @(posedge clk) begin
        #1;
        while (sdo_q.size() > 0 && sdo_q[0].c <= cyc) begin
            exp_sdo = sdo_q[0].v;
            void'(sdo_q.pop_front());
        end
    end

    // Per-cycle comparison; strobe checks also cover R10 (exclusive, single cycle)
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic ew, ex;
            logic [2:0] ech;
            logic [11:0] ed;
            ew = 0; ex = 0; ech = 0; ed = 0;
            if (cmt_q.size() > 0 && cmt_q[0].c == cyc) begin
                ew = (cmt_q[0].kind == 1);
                ex = (cmt_q[0].kind == 2);
                ech = cmt_q[0].ch; ed = cmt_q[0].d;
                void'(cmt_q.pop_front());
            end
            check("R6 sdo_o", 32'(sdo_o), 32'(exp_sdo));
            check({cur_req, " R7 R10 wr_stb_o"}, 32'(wr_stb_o), 32'(ew));
            check({cur_req, " R7 R10 xfer_all_o"}, 32'(xfer_all_o), 32'(ex));
            if (ew) begin
                check({cur_req, " wr_chan_o"}, 32'(wr_chan_o), 32'(ech));
                check({cur_req, " wr_data_o"}, 32'(wr_data_o), 32'(ed));
            end
        end
    end

    initial begin
        tk(3);
        // R1: quiet during reset
        check("R1 wr_stb_o", 32'(wr_stb_o), 0);
        check("R1 xfer_all_o", 32'(xfer_all_o), 0);
        check("R1 sdo_o", 32'(sdo_o), 0);
        tk(2);
        rst = 1'b0;
        tk(4);

        cur_req = "R2";
        frame({1'b0, 4'd3, 12'hA5C}, 16);
        frame({1'b0, 4'd7, 12'hFFF}, 16);
        frame({1'b0, 4'd0, 12'h001}, 16);
        frame({1'b0, 4'd5, 12'h3C6}, 16);

        cur_req = "R3";
        frame({1'b0, 4'd2, 12'h123}, 15);
        frame({4'd1, 12'h456, 1'b1}, 17);

        cur_req = "R4";
        frame({1'b0, 4'b1000, 12'h7E1}, 16);

        cur_req = "R5";
        frame({1'b0, 4'b1111, 12'hABC}, 16);
        frame({1'b0, 4'b1010, 12'h0F0}, 16);
        frame({1'b0, 4'b1110, 12'h999}, 16);

        cur_req = "R8";
        for (int k = 0; k < 6; k++) begin
            apply(1'b1, 1'b0, k[0]); tk(4);
            apply(1'b1, 1'b1, k[0]); tk(4);
        end
        tk(6);

        // R9: select high for one system clock, next first bit falls with select low
        cur_req = "R9";
        begin
            logic [15:0] a, b;
            a = {4'd6, 12'hC3A};
            b = {4'd1, 12'h5D2};
            apply(1'b0, 1'b1, 1'b0); tk(4);
            for (int i = 15; i >= 0; i--) bit_cycle(a[i]);
            apply(1'b1, 1'b1, 1'b0); tk(1);
            apply(1'b0, 1'b0, b[15]); tk(4);
            apply(1'b0, 1'b1, b[15]); tk(2);
            for (int i = 14; i >= 0; i--) bit_cycle(b[i]);
            apply(1'b1, 1'b1, 1'b0); tk(10);
        end

        cur_req = "R2";
        frame({1'b0, 4'd4, 12'h800}, 16);
        tk(10);
        check("R2 R3 pending commits", 32'(cmt_q.size()), 0);
        finish_run();
    end
endmodule